// File: doc/BRIEF.md
# Programmable Period Pulse Generator

A loadable counter that emits a single-cycle pulse once every `period + 1` enabled clock cycles. The interval is set by an input value, not by where a binary counter wraps. When the counter reaches its end state, it reloads itself through a 2:1 select. That select picks the start value on a reload and the stepped count otherwise.

Two directions are offered. In down mode the counter starts at `period`, steps toward zero and reloads `period` after zero. A period of 8 therefore gives a pulse every 9 cycles. In up mode it starts at 0, climbs to `period` and clears, so a compare value of 59 turns a 60-per-second tick into one pulse per second.

The mode input is sampled only when the counter reloads: at reset, on an external load, or at terminal count. An external load restarts the current period at once.

Top module: `pulse_timer`

## Requirements
- R1: While `rst` is high at a clock edge, the next state is `count` = `period` if `mode` is 0 (down) or `count` = 0 if `mode` is 1 (up), with `pulse` = 0.
- R2: In down mode with `en` high, each clock lowers `count` by one. After `count` = 0, the next value is `period`.
- R3: With `en` and `load` both low, `count` keeps its value and `pulse` is 0 on the next cycle.
- R4: When `load` is high, the next `count` is the start value for the current `mode` input (`period` for down, 0 for up), whatever `en` is. `pulse` is 0 on the next cycle.
- R5: `pulse` is high for exactly the one cycle after an enabled, non-load cycle in which the counter sat in its end state (0 in down mode, `period` in up mode). With `period` ≥ 1 it is high once per `period + 1` enabled cycles.
- R6: With `period` = 0 in down mode, `count` stays 0 and `pulse` is high on every cycle that follows an enabled cycle.
- R7: In up mode with `en` high, `count` climbs by one per clock. After `count` = `period`, the next value is 0. With `period` = 59 this gives one pulse per 60 cycles.
- R8: A change on `mode` does not alter the direction until the next reload. At that reload the counter takes the new mode's start value and then counts the new way.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Count enable |
| mode | input | 1 | 0 = down with reload, 1 = up with compare-clear |
| load | input | 1 | External reload request, takes priority over counting |
| period | input | W | Reload value (down) or compare value (up) |
| count | output | W | Current counter value |
| pulse | output | 1 | Registered single-cycle period pulse |

## Verification
`count` and `pulse` are both registered, so every result is due one clock edge after the inputs that cause it. The bench changes inputs 1 ns after a rising edge and reads the outputs 1 ns after the next rising edge. Each observation therefore reflects exactly one edge of stimulus. Within a run, the expected value after the k-th enabled edge is computed in closed form from k and `period`, and `pulse` is expected exactly on the edges where k is a multiple of `period + 1`.

// File: rtl/pulse_timer.sv
module pulse_timer #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         mode,
  input  logic         load,
  input  logic [W-1:0] period,
  output logic [W-1:0] count,
  output logic         pulse
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  logic         up_q;
  logic         tc;
  logic         reload;
  logic [W-1:0] start;
  logic [W-1:0] nxt;

  assign tc     = up_q ? (count == period) : (count == '0);
  assign start  = mode ? '0 : period;
  assign reload = load | (en & tc);
  assign nxt    = reload ? start : (up_q ? count + ONE : count - ONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= start;
      up_q  <= mode;
      pulse <= 1'b0;
    end else begin
      pulse <= en & ~load & tc;
      if (load | en) count <= nxt;
      if (reload)    up_q  <= mode;
    end
  end

  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (!pulse && count == ($past(mode) ? '0 : $past(period))));

  a_r3_hold: assert property (@(posedge clk) disable iff (rst)
    (!en && !load) |=> ($stable(count) && !pulse));

  a_r4_load_priority: assert property (@(posedge clk) disable iff (rst)
    load |=> (!pulse && count == ($past(mode) ? '0 : $past(period))));

  a_r2_down_step: assert property (@(posedge clk) disable iff (rst)
    (en && !load && !up_q && count != '0) |=> (count == $past(count) - ONE));

  a_r7_up_step: assert property (@(posedge clk) disable iff (rst)
    (en && !load && up_q && count != period) |=> (count == $past(count) + ONE));

  a_r5_pulse_at_end: assert property (@(posedge clk) disable iff (rst)
    (en && !load && tc) |=> pulse);
endmodule

// File: tb/pulse_timer_test.sv
module pulse_timer_test;
  localparam int W = 6;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         en = 1'b0;
  logic         mode = 1'b0;
  logic         load = 1'b0;
  logic [W-1:0] period = '0;
  logic [W-1:0] count;
  logic         pulse;

  int total = 0;
  int bad   = 0;

  pulse_timer #(.W(W)) uut (
    .clk(clk), .rst(rst), .en(en), .mode(mode), .load(load),
    .period(period), .count(count), .pulse(pulse)
  );

  always #5 clk = ~clk;

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic m, input int p);
    rst = 1'b1; en = 1'b0; load = 1'b0; mode = m; period = W'(p);
    step();
    check("R1 count", int'(count), m ? 0 : p);
    check("R1 pulse", int'(pulse), 0);
    rst = 1'b0;
  endtask

  task automatic run_down(input int p, input int cycles);
    do_reset(1'b0, p);
    en = 1'b1;
    for (int k = 1; k <= cycles; k++) begin
      step();
      check(p == 0 ? "R6 count" : "R2 count", int'(count), p - (k % (p + 1)));
      check(p == 0 ? "R6 pulse" : "R5 pulse", int'(pulse), (k % (p + 1)) == 0 ? 1 : 0);
    end
    en = 1'b0;
  endtask

  task automatic run_up(input int p, input int cycles);
    int pulses = 0;
    do_reset(1'b1, p);
    en = 1'b1;
    for (int k = 1; k <= cycles; k++) begin
      step();
      check("R7 count", int'(count), k % (p + 1));
      check("R5 pulse", int'(pulse), (k % (p + 1)) == 0 ? 1 : 0);
      pulses += int'(pulse);
    end
    check("R7 pulse tally", pulses, cycles / (p + 1));
    en = 1'b0;
  endtask

  task automatic run_hold();
    int held;
    do_reset(1'b0, 7);
    en = 1'b1;
    step(); step();
    held = int'(count);
    check("R2 before hold", held, 5);
    en = 1'b0;
    for (int k = 0; k < 5; k++) begin
      step();
      check("R3 count", int'(count), held);
      check("R3 pulse", int'(pulse), 0);
    end
  endtask

  task automatic run_load();
    do_reset(1'b0, 10);
    en = 1'b1;
    step(); step(); step();
    check("R2 before load", int'(count), 7);
    load = 1'b1; period = W'(20);
    step();
    load = 1'b0;
    check("R4 count", int'(count), 20);
    check("R4 pulse", int'(pulse), 0);
    step();
    check("R4 resumes", int'(count), 19);
    period = W'(0);
    load = 1'b1;
    step();
    check("R4 at zero count", int'(count), 0);
    check("R4 no pulse", int'(pulse), 0);
    load = 1'b0; en = 1'b0;
    period = W'(3); mode = 1'b1; load = 1'b1;
    step();
    load = 1'b0;
    check("R4 up start", int'(count), 0);
    en = 1'b1;
    step();
    check("R4 up counts", int'(count), 1);
    en = 1'b0; mode = 1'b0;
  endtask

  task automatic run_mode_change();
    int exp_c[6] = '{2, 1, 0, 0, 1, 2};
    int exp_p[6] = '{0, 0, 0, 1, 0, 0};
    do_reset(1'b0, 5);
    en = 1'b1;
    step(); step();
    check("R2 before switch", int'(count), 3);
    mode = 1'b1;
    for (int k = 0; k < 6; k++) begin
      step();
      check("R8 count", int'(count), exp_c[k]);
      check("R8 pulse", int'(pulse), exp_p[k]);
    end
    en = 1'b0; mode = 1'b0;
  endtask

  initial begin
    #10000000;
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1;
    run_down(8, 30);
    run_down(1, 8);
    run_down(0, 6);
    run_down(63, 130);
    run_up(59, 180);
    run_up(2, 9);
    run_hold();
    run_load();
    run_mode_change();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule